// File: doc/BRIEF.md
# Mailbox doorbell control-status register

This block is the host-facing 32-bit control and status word of a host-to-embedded-controller mailbox. It sits in front of a circular message buffer of 32-bit slots. The block stores none of the messages. It reports the buffer depth, the slot the host fills next and the slot the remote controller consumes next. It also holds the host's handshake and interrupt controls.

The host updates the low control bits with a single-cycle write strobe. The read word is always valid on `rd_data_o`. Two advance strobes move the pointers: `push_i` when the host has filled a slot and `pop_i` when the remote side has consumed one. Software works out occupancy from the two pointers and the depth.

The remote side sends in two things: a doorbell request toward the host and its own interrupt enable. It gets back single-cycle pulses that ring its doorbell, set its interrupt status, and clear its ready flag. The host interrupt is a level output.

Top module: `mbox_doorbell_csr`

## Requirements
- R1: After reset the read word is 0x02000000 with the default depth parameter (DEPTH_LOG2 = 1), and all pulse and interrupt outputs are 0.
- R2: Bits 31:24 hold a one-hot depth code with bit DEPTH_LOG2 set, meaning 2^DEPTH_LOG2 slots (legal depths 2 to 128). Host writes do not change it.
- R3: Bits 23:16 hold the write pointer, which advances by one on each `push_i` cycle. Bits 15:8 hold the read pointer, which advances by one on each `pop_i` cycle. Both wrap modulo the depth, and host writes to these fields have no effect.
- R4: A write with bit 4 = 1 while bit 4 reads 0 clears bit 3 (host ready) and returns both pointers to 0. In the cycle after that write edge, `remote_rdy_clr_o` is 1 for exactly one cycle. A write of bit 4 = 1 while bit 4 already reads 1 does none of this.
- R5: Writing 1 to bit 2 (doorbell request) makes it read 1 for one cycle. On the next edge it returns to 0 and `remote_is_set_o` pulses for one cycle.
- R6: `doorbell_o` pulses in the same cycle as `remote_is_set_o`, but only if `remote_ie_i` was 1 at that edge.
- R7: Bit 1 (interrupt status) becomes 1 on the edge after `remote_ig_i` is 1, whatever bit 0 holds. Writing 1 to bit 1 clears it. Writing 0 to bit 1 leaves it unchanged.
- R8: When `remote_ig_i` and a write of 1 to bit 1 occur in the same cycle, bit 1 ends up 1.
- R9: `host_irq_o` is 1 exactly while bit 1 and bit 0 (interrupt enable) both read 1.
- R10: Bits 7:5 always read 0, whatever is written there.
- R11: Bits 3 (host ready) and 0 (interrupt enable) store the written value, apart from the ready clear of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write data |
| rd_data_o | output | 32 | Current register word |
| push_i | input | 1 | Host filled a slot; advance write pointer |
| pop_i | input | 1 | Remote consumed a slot; advance read pointer |
| remote_ig_i | input | 1 | Remote side requests a host interrupt |
| remote_ie_i | input | 1 | Remote side's interrupt enable |
| remote_is_set_o | output | 1 | Pulse: set the remote interrupt status |
| doorbell_o | output | 1 | Pulse: interrupt message to the remote side |
| remote_rdy_clr_o | output | 1 | Pulse: clear the remote ready flag |
| host_irq_o | output | 1 | Level interrupt to the host |

## Verification
The hardest cases to reach are the ones decided inside a single cycle. The first is a status-set request and a host write-1-clear arriving on the same edge. The second is a reset request written while bit 4 already reads 1, which must not count as a rising edge. The bench reaches the first by driving `remote_ig_i` and the clearing write in the same half-cycle. It reaches the second by writing bit 4 twice in a row. It also fills the pointers before the reset request, so that their return to 0 can be seen.

// File: rtl/mbox_csr_pkg.sv
package mbox_csr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned BIT_IE   = 0;
  localparam int unsigned BIT_IS   = 1;
  localparam int unsigned BIT_IG   = 2;
  localparam int unsigned BIT_RDY  = 3;
  localparam int unsigned BIT_RST  = 4;
  localparam int unsigned RSVD_W   = 3;
  localparam int unsigned N_PTR    = 2;
  localparam int unsigned PTR_WR   = 0;
  localparam int unsigned PTR_RD   = 1;
endpackage

// File: rtl/mbox_ring_ptr.sv
module mbox_ring_ptr #(
  parameter int unsigned PTR_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_q;

  // power-of-two depth: natural rollover gives the wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (adv_i)  ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_MAX && adv_i && !clr_i) |=> (ptr_q == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ptr_q));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0));
endmodule

// File: rtl/mbox_ctl_bits.sv
module mbox_ctl_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_ie_i,
  input  logic wr_rdy_i,
  input  logic wr_rst_i,
  output logic ie_o,
  output logic rdy_o,
  output logic rst_o,
  output logic rst_rise_o,
  output logic rdy_clr_o
);
  logic ie_q, rdy_q, rst_q, rdy_clr_q;
  logic rise;

  assign rise = wr_en_i && wr_rst_i && !rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q      <= 1'b0;
      rdy_q     <= 1'b0;
      rst_q     <= 1'b0;
      rdy_clr_q <= 1'b0;
    end else begin
      rdy_clr_q <= rise;
      if (wr_en_i) begin
        ie_q  <= wr_ie_i;
        rst_q <= wr_rst_i;
      end
      if (rise)         rdy_q <= 1'b0;
      else if (wr_en_i) rdy_q <= wr_rdy_i;
    end
  end

  assign ie_o       = ie_q;
  assign rdy_o      = rdy_q;
  assign rst_o      = rst_q;
  assign rst_rise_o = rise;
  assign rdy_clr_o  = rdy_clr_q;

  p_rise_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_rst_i && !rst_q) |=> (!rdy_q && rdy_clr_q));

  p_no_rerise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rdy_clr_q);

  p_pulse_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_clr_q |=> !rdy_clr_q);

  p_ie_store_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ie_q == $past(wr_ie_i)));
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ig_i,
  input  logic clr_is_i,
  input  logic remote_ig_i,
  input  logic remote_ie_i,
  input  logic ie_i,
  output logic ig_o,
  output logic is_o,
  output logic remote_is_set_o,
  output logic doorbell_o,
  output logic host_irq_o
);
  logic ig_q, is_q, is_set_q, db_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ig_q     <= 1'b0;
      is_q     <= 1'b0;
      is_set_q <= 1'b0;
      db_q     <= 1'b0;
    end else begin
      // pending request is consumed on the next edge
      ig_q     <= set_ig_i;
      is_set_q <= ig_q;
      db_q     <= ig_q && remote_ie_i;
      // set has priority over write-1-clear
      if (remote_ig_i)   is_q <= 1'b1;
      else if (clr_is_i) is_q <= 1'b0;
    end
  end

  assign ig_o            = ig_q;
  assign is_o            = is_q;
  assign remote_is_set_o = is_set_q;
  assign doorbell_o      = db_q;
  assign host_irq_o      = is_q && ie_i;

  p_ig_self_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ig_q && !set_ig_i) |=> !ig_q);

  p_ig_fires_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ig_q |=> is_set_q);

  p_db_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ig_q && !remote_ie_i) |=> !db_q);

  p_db_with_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_q |-> is_set_q);

  p_is_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_q && !clr_is_i) |=> is_q);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remote_ig_i |=> is_q);
endmodule

// File: rtl/mbox_doorbell_csr.sv
module mbox_doorbell_csr
  import mbox_csr_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              remote_ig_i,
  input  logic              remote_ie_i,
  output logic              remote_is_set_o,
  output logic              doorbell_o,
  output logic              remote_rdy_clr_o,
  output logic              host_irq_o
);
  localparam int unsigned PTR_W = DEPTH_LOG2;
  localparam logic [FIELD_W-1:0] DEPTH_CODE = FIELD_W'(1 << DEPTH_LOG2);

  logic             ie, rdy, rst_req, rst_rise;
  logic             ig, is;
  logic [N_PTR-1:0] adv;
  logic [PTR_W-1:0] ptr [N_PTR];

  initial begin
    if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 7)
      $error("DEPTH_LOG2 out of range 1..7");
  end

  assign adv[PTR_WR] = push_i;
  assign adv[PTR_RD] = pop_i;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    mbox_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (rst_rise),
      .adv_i  (adv[g]),
      .ptr_o  (ptr[g])
    );
  end

  mbox_ctl_bits u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_ie_i    (wr_data_i[BIT_IE]),
    .wr_rdy_i   (wr_data_i[BIT_RDY]),
    .wr_rst_i   (wr_data_i[BIT_RST]),
    .ie_o       (ie),
    .rdy_o      (rdy),
    .rst_o      (rst_req),
    .rst_rise_o (rst_rise),
    .rdy_clr_o  (remote_rdy_clr_o)
  );

  mbox_irq_ctl u_irq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .set_ig_i        (wr_en_i && wr_data_i[BIT_IG]),
    .clr_is_i        (wr_en_i && wr_data_i[BIT_IS]),
    .remote_ig_i     (remote_ig_i),
    .remote_ie_i     (remote_ie_i),
    .ie_i            (ie),
    .ig_o            (ig),
    .is_o            (is),
    .remote_is_set_o (remote_is_set_o),
    .doorbell_o      (doorbell_o),
    .host_irq_o      (host_irq_o)
  );

  assign rd_data_o = {DEPTH_CODE,
                      FIELD_W'(ptr[PTR_WR]),
                      FIELD_W'(ptr[PTR_RD]),
                      {RSVD_W{1'b0}},
                      rst_req, rdy, ig, is, ie};

  p_irq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> (rd_data_o[BIT_IS] && rd_data_o[BIT_IE]));

  p_rst_ptrs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_RST] && !rd_data_o[BIT_RST])
      |=> (rd_data_o[23:8] == '0 && !rd_data_o[BIT_RDY]));
endmodule

// File: tb/mbox_doorbell_csr_test.sv
module mbox_doorbell_csr_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        push = 1'b0, pop = 1'b0;
  logic        r_ig = 1'b0, r_ie = 1'b0;
  logic        r_is_set, db, r_rdy_clr, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_doorbell_csr uut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .wr_en_i          (wr_en),
    .wr_data_i        (wr_data),
    .rd_data_o        (rd_data),
    .push_i           (push),
    .pop_i            (pop),
    .remote_ig_i      (r_ig),
    .remote_ie_i      (r_ie),
    .remote_is_set_o  (r_is_set),
    .doorbell_o       (db),
    .remote_rdy_clr_o (r_rdy_clr),
    .host_irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset word", rd_data, 32'h0200_0000);
    chk("R1 reset outputs", {28'd0, r_is_set, db, r_rdy_clr, irq}, 32'd0);
  endtask

  task automatic t_rw_bits;
    wr(32'hFFFF_FFE9);
    chk("R11 ready/enable stored", {27'd0, rd_data[4:0]}, 32'h09);
    chk("R10 reserved read zero", {29'd0, rd_data[7:5]}, 32'd0);
    chk("R2 depth unchanged", {24'd0, rd_data[31:24]}, 32'h02);
    chk("R3 pointers not writable", {16'd0, rd_data[23:8]}, 32'd0);
    wr(32'h0000_0001);
    chk("R11 ready cleared by write", {27'd0, rd_data[4:0]}, 32'h01);
    wr(32'h0000_0009);
  endtask

  task automatic t_ptr;
    @(negedge clk); push = 1'b1;
    repeat (3) @(negedge clk);
    push = 1'b0;
    chk("R3 write pointer wraps", {24'd0, rd_data[23:16]}, 32'd1);
    chk("R3 read pointer idle", {24'd0, rd_data[15:8]}, 32'd0);
    pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    chk("R3 read pointer advances", {24'd0, rd_data[15:8]}, 32'd1);
  endtask

  task automatic t_doorbell;
    r_ie = 1'b1;
    wr(32'h0000_000D);
    chk("R5 request visible", {31'd0, rd_data[2]}, 32'd1);
    chk("R5 no early pulse", {30'd0, r_is_set, db}, 32'd0);
    @(negedge clk);
    chk("R5 request self-clears", {31'd0, rd_data[2]}, 32'd0);
    chk("R6 pulses with enable", {30'd0, r_is_set, db}, 32'd3);
    @(negedge clk);
    chk("R5 pulse one cycle", {30'd0, r_is_set, db}, 32'd0);
    r_ie = 1'b0;
    wr(32'h0000_000D);
    @(negedge clk);
    chk("R6 gated doorbell", {30'd0, r_is_set, db}, 32'd2);
  endtask

  task automatic t_status;
    @(negedge clk); r_ig = 1'b1;
    @(negedge clk); r_ig = 1'b0;
    chk("R7 status set", {31'd0, rd_data[1]}, 32'd1);
    chk("R9 irq with enable", {31'd0, irq}, 32'd1);
    wr(32'h0000_0009);
    chk("R7 write 0 keeps status", {31'd0, rd_data[1]}, 32'd1);
    wr(32'h0000_000B);
    chk("R7 write 1 clears", {31'd0, rd_data[1]}, 32'd0);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);
    wr(32'h0000_0008);
    @(negedge clk); r_ig = 1'b1;
    @(negedge clk); r_ig = 1'b0;
    chk("R7 set without enable", {31'd0, rd_data[1]}, 32'd1);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(32'h0000_0009);
    chk("R9 irq on enable", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_000B; r_ig = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; r_ig = 1'b0;
    chk("R8 set beats clear", {31'd0, rd_data[1]}, 32'd1);
  endtask

  task automatic t_reset_req;
    chk("R4 pointers nonzero before", {16'd0, rd_data[23:8]}, 32'h0101);
    wr(32'h0000_0019);
    chk("R4 ready and pointers cleared", {16'd0, rd_data[23:8]}, 32'd0);
    chk("R4 host ready cleared", {31'd0, rd_data[3]}, 32'd0);
    chk("R4 remote ready clear pulse", {31'd0, r_rdy_clr}, 32'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, r_rdy_clr}, 32'd0);
    @(negedge clk); push = 1'b1;
    @(negedge clk); push = 1'b0;
    wr(32'h0000_0019);
    chk("R4 no re-trigger when held", {31'd0, rd_data[3]}, 32'd1);
    chk("R4 pointer kept when held", {24'd0, rd_data[23:16]}, 32'd1);
    chk("R4 no pulse when held", {31'd0, r_rdy_clr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw_bits;
    t_ptr;
    t_doorbell;
    t_status;
    t_set_wins;
    t_reset_req;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule